// File: doc/BRIEF.md
# Prioritized Exception Entry and Return Sequencer

This block sequences exception entry and exception return for a simple in-order processor core. Twelve request lines, each with a fixed meaning, come in, and a separate soft-reset request sits above all of them. Every cycle the block masks the asynchronous lines with the enable bits of the machine state, then picks the single highest-priority request that remains. It stores the resume address and the old machine state in one of two save pairs: one pair for the critical class and one for the noncritical class. It then rewrites the machine state and sends the fetch unit a redirect to the handler vector.

The core also signals two return instructions. A normal return reloads the program counter and the machine state from the noncritical pair. A critical return does the same from the critical pair. The core supplies the address of the current instruction, the next sequential address, a flag that a multicycle instruction is in flight, and the vector base. Decode, translation, the timers and the handler contents are outside this block.

Top module: `trap_sequencer`

## Requirements
- R1: A soft-reset request beats every other input. On the next cycle it gives flush_o=1, target_o=RESET_VEC (default 0xFFFFFFFC) and msr_o=0, and it leaves both save pairs unchanged.
- R2: The request line index is the priority, and index 0 is the highest: 0 machine check, 1 debug, 2 critical pin, 3 watchdog, 4 program, 5 data storage, 6 TLB miss, 7 system call, 8 alignment, 9 external, 10 fixed interval, 11 programmable interval. cause_o reports the index that was taken.
- R3: Indices 0 to 3 write only the critical pair (cr_pc_o, cr_msr_o). Indices 4 to 11 write only the noncritical pair (nc_pc_o, nc_msr_o).
- R4: The saved address is cur_pc_i for indices 4, 5, 6 and 8. It is next_pc_i for index 7 (system call) and for the asynchronous indices 0 to 3 and 9 to 11.
- R5: An asynchronous exception taken while multicycle_i=1 saves cur_pc_i, because the aborted instruction is the one that resumes.
- R6: The saved state register of the written pair receives msr_o as it stood before the entry.
- R7: On entry, msr_o bit 15 (external enable) is cleared. A critical entry also clears bit 17 (critical enable). All other bits are kept.
- R8: Indices 9 to 11 are taken only while msr_o bit 15 is 1, and indices 2 and 3 only while msr_o bit 17 is 1. A masked line stays pending and is taken once its enable bit returns.
- R9: On an exception, target_o = {vec_base_i[31:16], (cause+1) shifted left by 8}.
- R10: flush_o is 1 in the cycle after each exception, return or soft reset, and 0 otherwise. take_o is 1 only after an exception.
- R11: rfi_i loads target_o and msr_o from the noncritical pair, and rfci_i loads them from the critical pair. If both are asserted, rfci_i wins.
- R12: When a return and a request arrive in the same cycle, only the return takes effect. The request is judged in the next cycle against the restored state.
- R13: msr_we_i loads msr_wdata_i into the machine state when no reset, return or exception happens in that cycle. After a hardware reset, msr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sys_reset_i | input | 1 | Soft-reset request |
| req_i | input | 12 | Exception request lines, indexed by priority |
| cur_pc_i | input | 32 | Address of the current instruction |
| next_pc_i | input | 32 | Next sequential instruction address |
| multicycle_i | input | 1 | A multicycle instruction is in flight |
| rfi_i | input | 1 | Normal return instruction |
| rfci_i | input | 1 | Critical return instruction |
| msr_we_i | input | 1 | Machine state write strobe from the core |
| msr_wdata_i | input | 32 | Machine state write data |
| vec_base_i | input | 32 | Handler vector base |
| msr_o | output | 32 | Current machine state |
| flush_o | output | 1 | One-cycle pipeline flush and redirect strobe |
| target_o | output | 32 | Redirect address |
| take_o | output | 1 | An exception was taken |
| cause_o | output | 4 | Index of the last exception taken |
| nc_pc_o | output | 32 | Noncritical saved address |
| nc_msr_o | output | 32 | Noncritical saved state |
| cr_pc_o | output | 32 | Critical saved address |
| cr_msr_o | output | 32 | Critical saved state |

## Verification
Several lines are raised in the same cycle (program with external and interval timer, critical pin with watchdog and external, debug with machine check), and each combination shows whether the arbiter grants the right winner. Requests are held while their enable bit is clear, which separates a masked line from a dropped line. Returns are issued together with a pending request, which shows whether the request is judged against the old state or the restored state. Synchronous faults, system calls and asynchronous lines with and without a multicycle instruction in flight show which of the two addresses gets saved.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int unsigned NCAUSE = 12;
   localparam int unsigned CW     = 4;

   typedef enum logic [CW-1:0] {
      C_MCHK  = 4'd0,
      C_DEBUG = 4'd1,
      C_CPIN  = 4'd2,
      C_WDOG  = 4'd3,
      C_PROG  = 4'd4,
      C_DSTOR = 4'd5,
      C_TLB   = 4'd6,
      C_SCALL = 4'd7,
      C_ALIGN = 4'd8,
      C_EXT   = 4'd9,
      C_FIT   = 4'd10,
      C_PIT   = 4'd11
   } cause_e;

   // critical class: saved into the second pair
   function automatic logic is_crit(input logic [CW-1:0] c);
      return c <= C_WDOG;
   endfunction

   // synchronous precise causes
   function automatic logic is_sync(input logic [CW-1:0] c);
      return (c >= C_PROG) && (c <= C_ALIGN);
   endfunction

   function automatic logic gated_by_ee(input logic [CW-1:0] c);
      return c >= C_EXT;
   endfunction

   function automatic logic gated_by_ce(input logic [CW-1:0] c);
      return (c == C_CPIN) || (c == C_WDOG);
   endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned N = NCAUSE
)(
   input  logic [N-1:0]  req_i,
   input  logic          ee_i,
   input  logic          ce_i,
   output logic          any_o,
   output logic [CW-1:0] idx_o
);
   logic [N-1:0] live;
   logic [N-1:0] grant;
   logic [N:0]   above;

   if (N > (1 << CW)) begin : g_bad_n
      $error("trap_arbiter: N exceeds cause width");
   end

   assign above[0] = 1'b0;

   for (genvar g = 0; g < N; g++) begin : g_line
      localparam logic [CW-1:0] ID = CW'(g);
      logic en;
      if (gated_by_ee(ID)) begin : g_ee
         assign en = ee_i;
      end else if (gated_by_ce(ID)) begin : g_ce
         assign en = ce_i;
      end else begin : g_free
         assign en = 1'b1;
      end
      assign live[g]    = req_i[g] & en;
      assign grant[g]   = live[g] & ~above[g];
      assign above[g+1] = above[g] | live[g];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx_o = idx_o | CW'(i);
      end
   end

   assign any_o = above[N];
endmodule

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned VEC_SHIFT = 8,
   parameter int unsigned VEC_MODE  = 0
)(
   input  logic [XLEN-1:0] base_i,
   input  logic [CW-1:0]   idx_i,
   output logic [XLEN-1:0] vec_o
);
   localparam int unsigned OFFW = 16;

   logic [OFFW-1:0] slot;
   logic [OFFW-1:0] off;

   if (VEC_SHIFT + CW + 1 > OFFW) begin : g_bad_shift
      $error("trap_vector: offset does not fit in 16 bits");
   end
   if (XLEN <= OFFW) begin : g_bad_xlen
      $error("trap_vector: XLEN too small");
   end

   assign slot = OFFW'(idx_i) + OFFW'(1);
   assign off  = slot << VEC_SHIFT;

   if (VEC_MODE == 0) begin : g_concat
      assign vec_o = {base_i[XLEN-1:OFFW], off};
   end else if (VEC_MODE == 1) begin : g_add
      assign vec_o = base_i + XLEN'(off);
   end else begin : g_bad_mode
      $error("trap_vector: VEC_MODE must be 0 or 1");
      assign vec_o = base_i;
   end
endmodule

// File: rtl/trap_save_pair.sv
module trap_save_pair #(
   parameter int unsigned XLEN = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] msr_i,
   output logic [XLEN-1:0] pc_q,
   output logic [XLEN-1:0] msr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         msr_q <= '0;
      end else if (we_i) begin
         pc_q  <= pc_i;
         msr_q <= msr_i;
      end
   end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int unsigned   XLEN      = 32,
   parameter int unsigned   EE_BIT    = 15,
   parameter int unsigned   CE_BIT    = 17,
   parameter int unsigned   VEC_SHIFT = 8,
   parameter int unsigned   VEC_MODE  = 0,
   parameter logic [XLEN-1:0] RESET_VEC = 32'hFFFF_FFFC
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_reset_i,
   input  logic [NCAUSE-1:0] req_i,
   input  logic [XLEN-1:0]   cur_pc_i,
   input  logic [XLEN-1:0]   next_pc_i,
   input  logic              multicycle_i,
   input  logic              rfi_i,
   input  logic              rfci_i,
   input  logic              msr_we_i,
   input  logic [XLEN-1:0]   msr_wdata_i,
   input  logic [XLEN-1:0]   vec_base_i,
   output logic [XLEN-1:0]   msr_o,
   output logic              flush_o,
   output logic [XLEN-1:0]   target_o,
   output logic              take_o,
   output logic [CW-1:0]     cause_o,
   output logic [XLEN-1:0]   nc_pc_o,
   output logic [XLEN-1:0]   nc_msr_o,
   output logic [XLEN-1:0]   cr_pc_o,
   output logic [XLEN-1:0]   cr_msr_o
);
   localparam int unsigned NPAIR = 2;
   localparam int unsigned P_NC  = 0;
   localparam int unsigned P_CR  = 1;
   localparam logic [XLEN-1:0] EE_MASK = XLEN'(1) << EE_BIT;
   localparam logic [XLEN-1:0] CE_MASK = XLEN'(1) << CE_BIT;

   if (EE_BIT >= XLEN || CE_BIT >= XLEN || EE_BIT == CE_BIT) begin : g_bad_bits
      $error("trap_sequencer: enable bit positions invalid");
   end

   logic            win_v;
   logic [CW-1:0]   win_idx;
   logic            ret_any;
   logic            take;
   logic            crit;
   logic [XLEN-1:0] save_pc;
   logic [XLEN-1:0] entry_msr;
   logic [XLEN-1:0] vec;
   logic [XLEN-1:0] msr_q;
   logic [NPAIR-1:0]           pair_we;
   logic [NPAIR-1:0][XLEN-1:0] pair_pc;
   logic [NPAIR-1:0][XLEN-1:0] pair_msr;

   trap_arbiter #(.N(NCAUSE)) i_arb (
      .req_i (req_i),
      .ee_i  (msr_q[EE_BIT]),
      .ce_i  (msr_q[CE_BIT]),
      .any_o (win_v),
      .idx_o (win_idx)
   );

   trap_vector #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .VEC_MODE(VEC_MODE)) i_vec (
      .base_i (vec_base_i),
      .idx_i  (win_idx),
      .vec_o  (vec)
   );

   assign ret_any = rfi_i | rfci_i;
   assign take    = win_v & ~sys_reset_i & ~ret_any;
   assign crit    = is_crit(win_idx);

   // resume address selection
   always_comb begin
      if (is_sync(win_idx)) begin
         save_pc = (win_idx == C_SCALL) ? next_pc_i : cur_pc_i;
      end else begin
         save_pc = multicycle_i ? cur_pc_i : next_pc_i;
      end
   end

   assign entry_msr = msr_q & ~(EE_MASK | (crit ? CE_MASK : '0));

   assign pair_we[P_NC] = take & ~crit;
   assign pair_we[P_CR] = take & crit;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      trap_save_pair #(.XLEN(XLEN)) i_pair (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (pair_we[p]),
         .pc_i  (save_pc),
         .msr_i (msr_q),
         .pc_q  (pair_pc[p]),
         .msr_q (pair_msr[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msr_q    <= '0;
         flush_o  <= 1'b0;
         target_o <= '0;
         take_o   <= 1'b0;
         cause_o  <= '0;
      end else begin
         flush_o <= sys_reset_i | ret_any | take;
         take_o  <= take;
         if (sys_reset_i) begin
            msr_q    <= '0;
            target_o <= RESET_VEC;
         end else if (rfci_i) begin
            msr_q    <= pair_msr[P_CR];
            target_o <= pair_pc[P_CR];
         end else if (rfi_i) begin
            msr_q    <= pair_msr[P_NC];
            target_o <= pair_pc[P_NC];
         end else if (take) begin
            msr_q    <= entry_msr;
            target_o <= vec;
            cause_o  <= win_idx;
         end else if (msr_we_i) begin
            msr_q    <= msr_wdata_i;
         end
      end
   end

   assign msr_o    = msr_q;
   assign nc_pc_o  = pair_pc[P_NC];
   assign nc_msr_o = pair_msr[P_NC];
   assign cr_pc_o  = pair_pc[P_CR];
   assign cr_msr_o = pair_msr[P_CR];
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
   import trap_pkg::*;
#(
   parameter int unsigned   XLEN      = 32,
   parameter int unsigned   EE_BIT    = 15,
   parameter int unsigned   CE_BIT    = 17,
   parameter logic [XLEN-1:0] RESET_VEC = 32'hFFFF_FFFC
)(
   input logic            clk,
   input logic            rst_n,
   input logic            sys_reset_i,
   input logic            rfi_i,
   input logic            rfci_i,
   input logic [XLEN-1:0] msr_o,
   input logic            flush_o,
   input logic [XLEN-1:0] target_o,
   input logic            take_o,
   input logic [CW-1:0]   cause_o,
   input logic [XLEN-1:0] nc_pc_o,
   input logic [XLEN-1:0] nc_msr_o,
   input logic [XLEN-1:0] cr_pc_o,
   input logic [XLEN-1:0] cr_msr_o
);
   assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_i |=> flush_o && target_o == RESET_VEC && msr_o == '0);

   assert_reset_keeps_pairs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_i |=> $stable(nc_pc_o) && $stable(cr_pc_o) && $stable(nc_msr_o) && $stable(cr_msr_o));

   assert_crit_leaves_nc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o <= 4'd3 |-> $stable(nc_pc_o) && $stable(nc_msr_o));

   assert_nc_leaves_crit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o > 4'd3 |-> $stable(cr_pc_o) && $stable(cr_msr_o));

   assert_crit_state_saved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o <= 4'd3 |-> cr_msr_o == $past(msr_o));

   assert_nc_state_saved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o > 4'd3 |-> nc_msr_o == $past(msr_o));

   assert_entry_clears_ee_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !msr_o[EE_BIT]);

   assert_crit_clears_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o <= 4'd3 |-> !msr_o[CE_BIT]);

   assert_ext_needs_ee_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && cause_o >= 4'd9 |-> $past(msr_o[EE_BIT]));

   assert_take_flushes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> flush_o);

   assert_rfi_restores_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rfi_i && !rfci_i && !sys_reset_i |=> msr_o == $past(nc_msr_o) && target_o == $past(nc_pc_o));

   assert_rfci_restores_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rfci_i && !sys_reset_i |=> msr_o == $past(cr_msr_o) && target_o == $past(cr_pc_o));

   assert_return_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi_i || rfci_i) |=> !take_o);
endmodule

bind trap_sequencer trap_sequencer_chk #(
   .XLEN(XLEN), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT), .RESET_VEC(RESET_VEC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .sys_reset_i(sys_reset_i), .rfi_i(rfi_i), .rfci_i(rfci_i),
   .msr_o(msr_o), .flush_o(flush_o), .target_o(target_o), .take_o(take_o),
   .cause_o(cause_o), .nc_pc_o(nc_pc_o), .nc_msr_o(nc_msr_o),
   .cr_pc_o(cr_pc_o), .cr_msr_o(cr_msr_o)
);

// File: tb/test_trap_sequencer.sv
module test_trap_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_reset_i = 1'b0;
   logic [11:0] req_i = '0;
   logic [31:0] cur_pc_i = '0, next_pc_i = '0;
   logic        multicycle_i = 1'b0, rfi_i = 1'b0, rfci_i = 1'b0, msr_we_i = 1'b0;
   logic [31:0] msr_wdata_i = '0;
   logic [31:0] vec_base_i = 32'hABCD_0000;
   logic [31:0] msr_o, target_o, nc_pc_o, nc_msr_o, cr_pc_o, cr_msr_o;
   logic        flush_o, take_o;
   logic [3:0]  cause_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   trap_sequencer i_trap_sequencer (
      .clk(clk), .rst_n(rst_n), .sys_reset_i(sys_reset_i), .req_i(req_i),
      .cur_pc_i(cur_pc_i), .next_pc_i(next_pc_i), .multicycle_i(multicycle_i),
      .rfi_i(rfi_i), .rfci_i(rfci_i), .msr_we_i(msr_we_i), .msr_wdata_i(msr_wdata_i),
      .vec_base_i(vec_base_i), .msr_o(msr_o), .flush_o(flush_o), .target_o(target_o),
      .take_o(take_o), .cause_o(cause_o), .nc_pc_o(nc_pc_o), .nc_msr_o(nc_msr_o),
      .cr_pc_o(cr_pc_o), .cr_msr_o(cr_msr_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference
   logic [31:0] m_msr, m_tgt;
   logic [31:0] m_pc [2];
   logic [31:0] m_sm [2];
   bit          m_fl, m_tk;
   int          m_cause;
   int          pick;
   int          pair;

   function automatic bit allowed(input int k, input logic [31:0] s);
      if (k >= 9) return s[15];
      if (k == 2 || k == 3) return s[17];
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_msr = 0; m_tgt = 0; m_fl = 0; m_tk = 0; m_cause = 0;
         m_pc[0] = 0; m_pc[1] = 0; m_sm[0] = 0; m_sm[1] = 0;
      end else begin
         m_fl = 0; m_tk = 0;
         if (sys_reset_i) begin
            m_fl = 1; m_tgt = 32'hFFFF_FFFC; m_msr = 0;
         end else if (rfci_i || rfi_i) begin
            pair = rfci_i ? 1 : 0;
            m_fl = 1; m_tgt = m_pc[pair]; m_msr = m_sm[pair];
         end else begin
            pick = -1;
            for (int k = 11; k >= 0; k--) if (req_i[k] && allowed(k, m_msr)) pick = k;
            if (pick >= 0) begin
               pair = (pick <= 3) ? 1 : 0;
               m_fl = 1; m_tk = 1; m_cause = pick;
               m_sm[pair] = m_msr;
               if (pick == 7) m_pc[pair] = next_pc_i;
               else if (pick >= 4 && pick <= 8) m_pc[pair] = cur_pc_i;
               else m_pc[pair] = multicycle_i ? cur_pc_i : next_pc_i;
               m_msr[15] = 1'b0;
               if (pair == 1) m_msr[17] = 1'b0;
               m_tgt = {vec_base_i[31:16], 16'((pick + 1) * 256)};
            end else if (msr_we_i) begin
               m_msr = msr_wdata_i;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(flush_o === m_fl, "R10 flush", 32'(flush_o), 32'(m_fl));
         check(take_o === m_tk, "R2 take", 32'(take_o), 32'(m_tk));
         if (m_tk) check(cause_o === 4'(m_cause), "R2 cause", 32'(cause_o), 32'(m_cause));
         if (m_fl) check(target_o === m_tgt, "R9 target", target_o, m_tgt);
         check(msr_o === m_msr, "R7 msr", msr_o, m_msr);
         check(nc_pc_o === m_pc[0], "R4 nc_pc", nc_pc_o, m_pc[0]);
         check(cr_pc_o === m_pc[1], "R4 cr_pc", cr_pc_o, m_pc[1]);
         check(nc_msr_o === m_sm[0], "R6 nc_msr", nc_msr_o, m_sm[0]);
         check(cr_msr_o === m_sm[1], "R6 cr_msr", cr_msr_o, m_sm[1]);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      checks++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check(msr_o == 0 && !flush_o, "R13 reset state", msr_o, 0);

      // R13: state write
      msr_we_i = 1; msr_wdata_i = 32'h0002_8001;
      tick(1);
      msr_we_i = 0;
      check(msr_o == 32'h0002_8001, "R13 msr write", msr_o, 32'h0002_8001);

      // program + external + interval timer at once
      cur_pc_i = 32'h1000; next_pc_i = 32'h1004;
      req_i = 12'h000 | (12'd1 << 4) | (12'd1 << 9) | (12'd1 << 11);
      tick(1);
      req_i = 12'd1 << 9;
      check(take_o && cause_o == 4 && nc_pc_o == 32'h1000, "R2 program wins", 32'(cause_o), 4);
      for (int i = 0; i < 3; i++) begin
         tick(1);
         check(!take_o, "R8 external masked", 32'(take_o), 0);
      end

      // return with pending external
      rfi_i = 1;
      tick(1);
      rfi_i = 0;
      check(msr_o == 32'h0002_8001 && target_o == 32'h1000 && !take_o, "R11 rfi restore", target_o, 32'h1000);
      tick(1);
      req_i = 0;
      check(take_o && cause_o == 9 && nc_pc_o == 32'h1004, "R12 deferred external", nc_pc_o, 32'h1004);

      // critical pin + watchdog + external
      msr_we_i = 1; msr_wdata_i = 32'h0002_8001;
      tick(1);
      msr_we_i = 0;
      cur_pc_i = 32'h2000; next_pc_i = 32'h2004;
      req_i = (12'd1 << 2) | (12'd1 << 3) | (12'd1 << 9);
      tick(1);
      req_i = (12'd1 << 3) | (12'd1 << 9);
      check(cause_o == 2 && cr_pc_o == 32'h2004 && nc_pc_o == 32'h1004, "R3 critical pair", cr_pc_o, 32'h2004);
      check(msr_o == 32'h1, "R7 critical clears both", msr_o, 32'h1);
      tick(2);
      check(!take_o, "R8 watchdog masked", 32'(take_o), 0);

      // critical return alongside pending requests
      rfci_i = 1;
      tick(1);
      rfci_i = 0;
      check(!take_o && target_o == 32'h2004 && msr_o == 32'h0002_8001, "R12 rfci first", target_o, 32'h2004);
      tick(1);
      req_i = 0;
      check(take_o && cause_o == 3, "R12 watchdog after rfci", 32'(cause_o), 3);

      // multicycle abort
      msr_we_i = 1; msr_wdata_i = 32'h0002_8001;
      tick(1);
      msr_we_i = 0;
      multicycle_i = 1; cur_pc_i = 32'h3000; next_pc_i = 32'h3004;
      req_i = 12'd1 << 9;
      tick(1);
      req_i = 0; multicycle_i = 0;
      check(nc_pc_o == 32'h3000, "R5 multicycle abort", nc_pc_o, 32'h3000);

      // system call saves next address
      cur_pc_i = 32'h4000; next_pc_i = 32'h4004;
      req_i = 12'd1 << 7;
      tick(1);
      req_i = 0;
      check(nc_pc_o == 32'h4004 && cause_o == 7, "R4 syscall next", nc_pc_o, 32'h4004);

      // both returns: critical wins
      rfi_i = 1; rfci_i = 1;
      tick(1);
      rfi_i = 0; rfci_i = 0;
      check(target_o == 32'h2004, "R11 rfci over rfi", target_o, 32'h2004);

      // debug + machine check
      req_i = 12'b11;
      tick(1);
      req_i = 0;
      check(cause_o == 0 && target_o == 32'hABCD_0100, "R2 machine check first", target_o, 32'hABCD_0100);

      // soft reset beats a request
      msr_we_i = 1; msr_wdata_i = 32'h0002_8001;
      tick(1);
      msr_we_i = 0;
      sys_reset_i = 1; req_i = 12'd1 << 9;
      tick(1);
      sys_reset_i = 0; req_i = 0;
      check(target_o == 32'hFFFF_FFFC && msr_o == 0 && !take_o && nc_pc_o == 32'h4004,
            "R1 soft reset", target_o, 32'hFFFF_FFFC);
      tick(1);
      check(!flush_o, "R10 single pulse", 32'(flush_o), 0);
      tick(1);
      summary();
   end
endmodule